// File: doc/BRIEF.md
# Command-Driven Two-Wire Serial Memory Master

This block is a byte-level master for a two-wire serial bus of the I2C kind, aimed at small serial memories. A processor writes one byte into a data register and a 4-bit command into a control field. Each command asks for exactly one bus operation:

- a START condition;
- a STOP condition;
- sending the data byte;
- receiving a byte and acknowledging it;
- receiving a last byte without an acknowledge.

The block produces the serial clock from a divider of the system clock and drives both lines as open-drain. It reports progress through a status byte and raises a one-cycle interrupt when an operation finishes.

Each serial bit spans four quarter-periods of `CLK_HZ/(4*SCK_HZ)` system clocks. SCL is low for the first two quarters and high for the last two. SDA is set at the start of the second quarter and sampled at the end of the fourth. Between operations SCL stays released (high), and SDA keeps the level it had at the end of the last operation.

The controller has five states:

- **IDLE**: waiting for a command. An accepted START command leads to **START**, an accepted STOP command to **STOP**, and any byte command to **DATA**.
- **START** and **STOP**: each runs four quarters and then returns to IDLE.
- **DATA**: runs eight bit slots and moves to **ACK** after the eighth.
- **ACK**: runs the ninth bit slot and returns to IDLE.

The no-op and undefined codes never leave IDLE.

Top module: `twi_cmd_master`

## Requirements
- R1: After reset the status byte reads 0x30 (bit 7 error = 0, bit 6 busy = 0, bit 5 receive-acknowledge = 1, bit 4 send-acknowledge = 1, bits 3:0 read 0). The data register reads 0x00, and neither SCL nor SDA is driven low.
- R2: Code 4'b1001 produces a START: SDA falls while SCL is high, and the operation ends with SCL high and SDA low.
- R3: Code 4'b0101 produces a STOP: SDA rises while SCL is high, and the operation ends with both lines high.
- R4: Code 4'b0011 sends the data register MSB first on eight SCL pulses, then releases SDA on a ninth pulse. Status bit 5 takes the SDA level sampled on that pulse (0 = acknowledged). Afterwards the data register holds the byte that was on the bus.
- R5: Code 4'b0001 samples eight bits MSB first into the data register, then drives SDA low on the ninth pulse. Status bit 5 is left unchanged, and bit 4 becomes 0.
- R6: Code 4'b0110 samples eight bits like R5 but leaves SDA released on the ninth pulse. Status bit 4 becomes 1.
- R7: Status bit 6 reads 1 from the cycle after a bus command is accepted until the operation ends. The interrupt output is high for exactly one cycle, the same cycle in which bit 6 first reads 0 again.
- R8: The SCL period during a byte is 4*QDIV system clocks. SCL is high whenever the block is not busy.
- R9: SDA changes only while SCL is low, except for the SDA edge of a START or STOP. No START or STOP edge appears during byte operations.
- R10: Any code other than 0000, 0001, 0011, 0101, 0110 and 1001 sets status bit 7. It causes no bus activity, no busy and no interrupt.
- R11: Code 0000 is a no-op: no bus activity, no busy, no interrupt, and it clears status bit 7. Every bus command also clears bit 7 when accepted.
- R12: Command writes and data writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 1 | Write strobe for the data register |
| data_in | input | DW | Byte written to the data register |
| wr_cmd | input | 1 | Write strobe for the command field |
| cmd_in | input | 4 | Command code |
| data_q | output | DW | Data register (received or sent byte) |
| status_q | output | 8 | {error, busy, receive-ack_n, send-ack_n, 4'b0} |
| irq | output | 1 | One-cycle pulse at the end of an operation |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
A wrong state or a mis-counted bit slot shows up at the first SCL edge that follows it. Such a fault adds or drops a pulse, which shifts the captured byte and the acknowledge bit seen by the memory model. The same fault moves the interrupt a whole bit time of 4*QDIV clocks early or late. A wrongly timed SDA change is seen immediately by the START/STOP edge counters, and a bad acknowledge or error flag is seen in the status byte compared at the interrupt. An accepted command that should have been ignored leaves a second, unexpected interrupt or a changed data byte within one operation.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        K_NOP,
        K_RXA,
        K_TX,
        K_STOP,
        K_RXL,
        K_START,
        K_BAD
    } kind_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_STOP,
        S_DATA,
        S_ACK
    } state_t;

    localparam logic [3:0] C_NOP   = 4'b0000;
    localparam logic [3:0] C_RXA   = 4'b0001;
    localparam logic [3:0] C_TX    = 4'b0011;
    localparam logic [3:0] C_STOP  = 4'b0101;
    localparam logic [3:0] C_RXL   = 4'b0110;
    localparam logic [3:0] C_START = 4'b1001;

endpackage

// File: rtl/twi_cmd_decode.sv
module twi_cmd_decode
    import twi_pkg::*;
(
    input  logic [3:0] code,
    output kind_t      kind
);

    always_comb begin
        unique case (code)
            C_NOP:   kind = K_NOP;
            C_RXA:   kind = K_RXA;
            C_TX:    kind = K_TX;
            C_STOP:  kind = K_STOP;
            C_RXL:   kind = K_RXL;
            C_START: kind = K_START;
            default: kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/twi_qtick.sv
module twi_qtick #(
    parameter int QDIV = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/twi_engine.sv
module twi_engine
    import twi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [DW-1:0] data_in,
    input  logic          wr_cmd,
    input  kind_t         kind,
    input  logic          tick,
    input  logic          sda_in,
    output logic          busy,
    output logic          err,
    output logic          rxa_n,
    output logic          txa_n,
    output logic          irq,
    output logic [DW-1:0] sh,
    output logic          scl_oe,
    output logic          sda_oe
);

    localparam int BW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);

    state_t        st, st_n;
    kind_t         kq;
    logic [1:0]    ph;
    logic [BW-1:0] bitn;
    logic          endq;

    assign busy = (st != S_IDLE);
    assign endq = tick && (ph == 2'd3);

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: begin
                if (wr_cmd) begin
                    unique case (kind)
                        K_START:           st_n = S_START;
                        K_STOP:            st_n = S_STOP;
                        K_TX, K_RXA, K_RXL: st_n = S_DATA;
                        default:           st_n = S_IDLE;
                    endcase
                end
            end
            S_START, S_STOP: if (endq) st_n = S_IDLE;
            S_DATA:          if (endq && bitn == LASTBIT) st_n = S_ACK;
            S_ACK:           if (endq) st_n = S_IDLE;
            default:         st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kq     <= K_NOP;
            ph     <= 2'd0;
            bitn   <= '0;
            sh     <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            err    <= 1'b0;
            rxa_n  <= 1'b1;
            txa_n  <= 1'b1;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (st == S_IDLE) begin
                if (wr_data) sh <= data_in;
                if (wr_cmd) begin
                    unique case (kind)
                        K_NOP: err <= 1'b0;
                        K_BAD: err <= 1'b1;
                        default: begin
                            err    <= 1'b0;
                            kq     <= kind;
                            ph     <= 2'd0;
                            bitn   <= '0;
                            scl_oe <= 1'b1;
                        end
                    endcase
                end
            end else if (tick) begin
                ph <= ph + 2'd1;
                unique case (st)
                    S_START: begin
                        unique case (ph)
                            2'd0: sda_oe <= 1'b0;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b1;
                            2'd3: irq    <= 1'b1;
                        endcase
                    end
                    S_STOP: begin
                        unique case (ph)
                            2'd0: sda_oe <= 1'b1;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b0;
                            2'd3: irq    <= 1'b1;
                        endcase
                    end
                    S_DATA: begin
                        unique case (ph)
                            2'd0: sda_oe <= (kq == K_TX) ? ~sh[DW-1] : 1'b0;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: ;
                            2'd3: begin
                                sh     <= {sh[DW-2:0], sda_in};
                                scl_oe <= 1'b1;
                                bitn   <= bitn + 1'b1;
                            end
                        endcase
                    end
                    S_ACK: begin
                        unique case (ph)
                            2'd0: sda_oe <= (kq == K_RXA);
                            2'd1: scl_oe <= 1'b0;
                            2'd2: ;
                            2'd3: begin
                                if (kq == K_TX) rxa_n <= sda_in;
                                else            txa_n <= (kq != K_RXA);
                                irq <= 1'b1;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: SDA moves under a high SCL only inside START or STOP
    a_r9_sda_edge_only_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
            |-> (st == S_START || st == S_STOP));

    // R8: SCL released whenever idle
    a_r8_idle_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scl_oe);

    // R10: undefined code raises error and stays idle
    a_r10_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && wr_cmd && kind == K_BAD) |=> (err && st == S_IDLE));

    // R12: command writes while busy leave the error flag alone
    a_r12_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd) |=> $stable(err));

endmodule

// File: rtl/twi_cmd_master.sv
module twi_cmd_master
    import twi_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int SCK_HZ = 78_000,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic [DW-1:0] data_in,
    input  logic          wr_cmd,
    input  logic [3:0]    cmd_in,
    output logic [DW-1:0] data_q,
    output logic [7:0]    status_q,
    output logic          irq,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_in
);

    localparam int QDIV = CLK_HZ / (4 * SCK_HZ);

    kind_t kind;
    logic  tick;
    logic  busy, err, rxa_n, txa_n;

    twi_cmd_decode u_dec (
        .code (cmd_in),
        .kind (kind)
    );

    twi_qtick #(.QDIV(QDIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    twi_engine #(.DW(DW)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .data_in (data_in),
        .wr_cmd  (wr_cmd),
        .kind    (kind),
        .tick    (tick),
        .sda_in  (sda_in),
        .busy    (busy),
        .err     (err),
        .rxa_n   (rxa_n),
        .txa_n   (txa_n),
        .irq     (irq),
        .sh      (data_q),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    assign status_q = {err, busy, rxa_n, txa_n, 4'b0000};

    // R7: interrupt only in the cycle where busy has just fallen
    a_r7_irq_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R7: interrupt is a single-cycle pulse
    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: tb/sim_twi_cmd_master.sv
module sim_twi_cmd_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       wr_cmd = 1'b0;
    logic [3:0] cmd_in = 4'h0;
    logic [7:0] data_q, status_q;
    logic       irq, scl_oe, sda_oe;
    logic       sl_pull = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | sl_pull);

    always #4 clk = ~clk;

    twi_cmd_master #(.CLK_HZ(125_000_000), .SCK_HZ(7_812_500), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .data_in(data_in),
        .wr_cmd(wr_cmd), .cmd_in(cmd_in), .data_q(data_q), .status_q(status_q),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    // memory model
    int         nedge = 0;
    int         mode = 0;      // 0 quiet, 1 listen, 2 talk
    logic       sl_ack = 1'b0;
    logic [7:0] sl_byte = 8'h00;
    logic [8:0] cap = '0;
    int         nstart = 0, nstop = 0;
    realtime    t_last = 0, per_last = 0;

    always @(negedge scl_line) begin
        nedge++;
        if (mode == 2 && nedge <= 8) sl_pull = ~sl_byte[8 - nedge];
        else if (mode == 1 && nedge == 9) sl_pull = sl_ack;
        else sl_pull = 1'b0;
    end

    always @(posedge scl_line) begin
        cap = {cap[7:0], sda_line};
        per_last = $realtime - t_last;
        t_last = $realtime;
    end

    always @(negedge sda_line) if (scl_line === 1'b1) nstart++;
    always @(posedge sda_line) if (scl_line === 1'b1) nstop++;

    // scoreboard
    logic [7:0] qs[$];
    logic [7:0] qd[$];
    string      qt[$];
    int         nirq = 0;

    always @(negedge clk) begin
        if (rst_n && irq === 1'b1) begin
            nirq++;
            if (qs.size() == 0) begin
                chk("R7 unexpected irq", 1, 0);
            end else begin
                chk({qt[0], " status"}, status_q, qs[0]);
                chk({qt[0], " data"}, data_q, qd[0]);
                void'(qs.pop_front());
                void'(qd.pop_front());
                void'(qt.pop_front());
            end
        end
    end

    logic e_rx = 1'b1, e_tx = 1'b1;
    logic [7:0] e_dat = 8'h00;

    function automatic logic [7:0] est();
        return {2'b00, e_rx, e_tx, 4'b0000};
    endfunction

    task automatic wdat(input logic [7:0] d);
        @(negedge clk); wr_data = 1'b1; data_in = d;
        @(negedge clk); wr_data = 1'b0;
    endtask

    task automatic op(input logic [3:0] code, input string tag, input bit poke);
        qs.push_back(est()); qd.push_back(e_dat); qt.push_back(tag);
        nedge = 0;
        @(negedge clk); wr_cmd = 1'b1; cmd_in = code;
        @(negedge clk); wr_cmd = 1'b0;
        chk("R7 busy after accept", status_q[6], 1);
        if (poke) begin
            wr_cmd = 1'b1; cmd_in = 4'b0101; wr_data = 1'b1; data_in = 8'hFF;
            @(negedge clk); wr_cmd = 1'b0; wr_data = 1'b0;
        end
        while (qs.size() != 0) @(negedge clk);
        @(negedge clk);
        chk("R8 scl parked high", scl_line, 1);
        chk("R7 busy low after end", status_q[6], 0);
    endtask

    task automatic bad_cmd(input logic [3:0] code, input logic exp_err, input string tag);
        int ni, ns, np;
        ni = nirq; ns = nstart; np = nstop;
        @(negedge clk); wr_cmd = 1'b1; cmd_in = code;
        @(negedge clk); wr_cmd = 1'b0;
        chk({tag, " no busy"}, status_q[6], 0);
        repeat (40) @(negedge clk);
        chk({tag, " error flag"}, status_q[7], exp_err);
        chk({tag, " no irq"}, nirq, ni);
        chk({tag, " no bus edge"}, {nstart[15:0], nstop[15:0]}, {ns[15:0], np[15:0]});
        chk({tag, " scl high"}, scl_line, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", status_q, 8'h30);
        chk("R1 data", data_q, 8'h00);
        chk("R1 lines", {scl_line, sda_line}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        nstart = 0; nstop = 0;

        wdat(8'hA5); e_dat = 8'hA5;
        mode = 0; op(4'b1001, "R2 start", 0);
        chk("R2 start edge", nstart, 1);
        chk("R2 sda low after", sda_line, 0);

        mode = 1; sl_ack = 1'b1; e_rx = 1'b0;
        op(4'b0011, "R4 tx ack", 0);
        chk("R4 bus byte", cap[8:1], 8'hA5);
        chk("R8 scl period", int'(per_last), 128);
        chk("R9 no cond in byte", {nstart[15:0], nstop[15:0]}, 32'h0001_0000);

        wdat(8'h3C); e_dat = 8'h3C;
        mode = 1; sl_ack = 1'b0; e_rx = 1'b1;
        op(4'b0011, "R12 tx nack with busy writes", 1);
        chk("R4 bus byte nack", cap[8:1], 8'h3C);
        chk("R12 no stop from busy cmd", nstop, 0);

        mode = 2; sl_byte = 8'hC3; e_tx = 1'b0; e_dat = 8'hC3;
        op(4'b0001, "R5 rx ack", 0);
        chk("R5 master ack level", cap[0], 0);

        mode = 2; sl_byte = 8'h5A; e_tx = 1'b1; e_dat = 8'h5A;
        op(4'b0110, "R6 rx last", 0);
        chk("R6 ninth bit released", cap[0], 1);
        chk("R9 no cond in rx", {nstart[15:0], nstop[15:0]}, 32'h0001_0000);

        mode = 0; op(4'b0101, "R3 stop", 0);
        chk("R3 stop edge", nstop, 1);
        chk("R3 lines high", {scl_line, sda_line}, 2'b11);

        bad_cmd(4'b0111, 1'b1, "R10 code 0111");
        bad_cmd(4'b0000, 1'b0, "R11 nop clears");
        bad_cmd(4'b1111, 1'b1, "R10 code 1111");
        mode = 0; op(4'b1001, "R11 valid cmd clears error", 0);
        chk("R11 error clear", status_q[7], 0);
        op(4'b0101, "R3 stop again", 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule